// File: doc/BRIEF.md
# Four-Channel DAC Command Register Engine

This block is the byte-wide host side of a four-channel, 16-bit digital-to-analog converter whose output span is chosen per channel. It occupies a window of four consecutive byte addresses. The host places a code or span value in two data byte registers and then writes a command byte. The command byte holds an opcode in its upper nibble and a channel selector in its lower nibble. Each channel has an input register and an active register for its code and for its span. The active registers drive the output ports that feed the converter.

Commands can load input registers, copy input registers into active registers, or do both in one step. Each one targets a single channel, or every channel at once. Readback commands copy a stored input or active value into the data byte registers so the host can read it. A completion flag in the status byte falls when a command is accepted and rises a fixed number of cycles later. The window base is a parameter, so a second converter can sit four bytes higher on the same bus.

Top module: `dac_cmd_engine`

## Requirements
- R1: After reset, all input and active codes and spans are 0, both data bytes read 0, and the completion flag is 1.
- R2: Relative to BASE_ADDR, offset 0 is the data low byte, offset 1 is the data high byte, offset 2 is the command and offset 3 is status. Status reads as {done, 7'b0} and the command offset reads 0. A write to offset 3, or to any address outside the window, changes no state, and a read outside the window returns 0.
- R3: Opcode 3 loads {high byte, low byte} into the input code of the addressed channel. The active code is not changed.
- R4: Opcode 2 loads bits 3:0 of the low byte into the input span, and the high byte has no effect. Span codes 0 to 5 are valid. A code of 6 or more leaves the input span unchanged.
- R5: Opcode 4 copies the input code and span of the addressed channel into its active registers. The other channels stay as they are.
- R6: Opcode 5 copies input into active for every channel in the same cycle, whatever the channel field holds.
- R7: Opcodes 6 (span) and 7 (code) perform the write and then update the addressed channel, so the active value equals the newly written value.
- R8: Opcodes 8 (span) and 9 (code) write the addressed channel and then update all channels, and the new value reaches the active register in that same cycle.
- R9: The channel number is taken from command bits 2:1. A low nibble of 0xF addresses all channels for every write and update.
- R10: Opcode A reads back the input span, B the input code, C the active span and D the active code, each for the channel in bits 2:1. The value lands in the data bytes, with the low byte holding bits 7:0. A span comes back in bits 3:0 of the low byte, and the high byte is 0.
- R11: The completion flag goes to 0 in the cycle a command is written and returns to 1 exactly LATENCY cycles later. Opcode F and undefined opcodes change no stored value but still complete.
- R12: An instance with a different BASE_ADDR ignores accesses to another instance's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Host byte address |
| busWrEn | input | 1 | Host write strobe |
| busWrData | input | 8 | Host write byte |
| busRdData | output | 8 | Host read byte, combinational on busAddr |
| codeOut | output | NUM_CH*16 | Active codes, channel i at bits i*16 +: 16 |
| spanOut | output | NUM_CH*4 | Active spans, channel i at bits i*4 +: 4 |
| cmdDone | output | 1 | Completion flag, also status bit 7 |

## Verification
Several rules are checked by assertions on every cycle. Active registers hold whenever no update strobe fires, and the high data byte holds whenever neither a host write nor a readback targets it. No stored input span ever leaves the legal range, and at most one kind of register write is strobed per cycle. The completion flag only falls after a command write. The bench scenarios are needed to show the rest: which opcode and channel-field combinations reach which registers, that a write and an update-all in one command pass the new value through, the readback contents, the exact completion latency, and the isolation between two windows.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int CODE_W    = 2 * BYTE_W;
  localparam int SPAN_W    = 4;
  localparam int CH_W      = 2;
  localparam int NUM_CH    = 1 << CH_W;
  localparam int NUM_SPANS = 6;

  typedef enum logic [3:0] {
    OP_WR_SPAN         = 4'h2,
    OP_WR_CODE         = 4'h3,
    OP_UPD             = 4'h4,
    OP_UPD_ALL         = 4'h5,
    OP_WR_SPAN_UPD     = 4'h6,
    OP_WR_CODE_UPD     = 4'h7,
    OP_WR_SPAN_UPD_ALL = 4'h8,
    OP_WR_CODE_UPD_ALL = 4'h9,
    OP_RD_IN_SPAN      = 4'hA,
    OP_RD_IN_CODE      = 4'hB,
    OP_RD_ACT_SPAN     = 4'hC,
    OP_RD_ACT_CODE     = 4'hD,
    OP_NOP             = 4'hF
  } dacOp_e;

  typedef struct packed {
    logic            loWr;
    logic            hiWr;
    logic            wrCode;
    logic            wrSpan;
    logic            updOne;
    logic            updAll;
    logic            allCh;
    logic [CH_W-1:0] chan;
    logic            rdBack;
    logic            rdActive;
    logic            rdCode;
  } dacStrobe_t;
endpackage

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int              ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 5'h08,
  parameter int              LATENCY   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BYTE_W-1:0] busWrData,
  output dacStrobe_t        strb,
  output logic              winHit,
  output logic [1:0]        winOff,
  output logic              cmdDone
);
  localparam int LAT_W = $clog2(LATENCY + 1);

  logic [ADDR_W-1:0] relAddr;
  logic              cmdWr;
  logic [3:0]        opField;
  logic [LAT_W-1:0]  waitCnt;

  assign relAddr = busAddr - BASE_ADDR;
  assign winHit  = (relAddr >> 2) == '0;
  assign winOff  = relAddr[1:0];
  assign cmdWr   = busWrEn && winHit && (winOff == 2'd2);
  assign opField = busWrData[7:4];

  always_comb begin
    strb        = '0;
    strb.loWr   = busWrEn && winHit && (winOff == 2'd0);
    strb.hiWr   = busWrEn && winHit && (winOff == 2'd1);
    strb.chan   = busWrData[CH_W:1];
    strb.allCh  = busWrData[3:0] == 4'hF;
    if (cmdWr) begin
      case (opField)
        OP_WR_SPAN:         strb.wrSpan = 1'b1;
        OP_WR_CODE:         strb.wrCode = 1'b1;
        OP_UPD:             strb.updOne = 1'b1;
        OP_UPD_ALL:         strb.updAll = 1'b1;
        OP_WR_SPAN_UPD:     begin strb.wrSpan = 1'b1; strb.updOne = 1'b1; end
        OP_WR_CODE_UPD:     begin strb.wrCode = 1'b1; strb.updOne = 1'b1; end
        OP_WR_SPAN_UPD_ALL: begin strb.wrSpan = 1'b1; strb.updAll = 1'b1; end
        OP_WR_CODE_UPD_ALL: begin strb.wrCode = 1'b1; strb.updAll = 1'b1; end
        OP_RD_IN_SPAN:      strb.rdBack = 1'b1;
        OP_RD_IN_CODE:      begin strb.rdBack = 1'b1; strb.rdCode = 1'b1; end
        OP_RD_ACT_SPAN:     begin strb.rdBack = 1'b1; strb.rdActive = 1'b1; end
        OP_RD_ACT_CODE:     begin strb.rdBack = 1'b1; strb.rdActive = 1'b1; strb.rdCode = 1'b1; end
        default:            ;
      endcase
    end
  end

  // Completion flag: drops on command accept, rises LATENCY edges later.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      cmdDone <= 1'b1;
    end else if (cmdWr) begin
      waitCnt <= LAT_W'(LATENCY);
      cmdDone <= 1'b0;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
      if (waitCnt == LAT_W'(1)) cmdDone <= 1'b1;
    end
  end

  assert_done_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr |=> !cmdDone);
  assert_done_fall_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdDone) |-> $past(cmdWr));
  assert_single_write_kind_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCode, strb.wrSpan, strb.rdBack}));
endmodule

// File: rtl/dac_cmd_dp.sv
module dac_cmd_dp
  import dac_cmd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [BYTE_W-1:0]        busWrData,
  input  dacStrobe_t               strb,
  output logic [BYTE_W-1:0]        loReg,
  output logic [BYTE_W-1:0]        hiReg,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH*SPAN_W-1:0] spanOut
);
  logic [NUM_CH*CODE_W-1:0] inCodeFlat;
  logic [NUM_CH*SPAN_W-1:0] inSpanFlat;
  logic [CODE_W-1:0]        newCode;
  logic                     spanOk;
  logic [CODE_W-1:0]        rbCode;
  logic [SPAN_W-1:0]        rbSpan;
  logic [CODE_W-1:0]        rbVal;

  assign newCode = {hiReg, loReg};
  assign spanOk  = loReg[SPAN_W-1:0] < SPAN_W'(NUM_SPANS);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              selCh, updThis;
    logic [CODE_W-1:0] inCode, actCode, inCodeNext;
    logic [SPAN_W-1:0] inSpan, actSpan, inSpanNext;

    assign selCh      = strb.allCh || (strb.chan == CH_W'(i));
    assign updThis    = strb.updAll || (strb.updOne && selCh);
    assign inCodeNext = (strb.wrCode && selCh) ? newCode : inCode;
    assign inSpanNext = (strb.wrSpan && selCh && spanOk) ? loReg[SPAN_W-1:0] : inSpan;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        inCode  <= '0;
        inSpan  <= '0;
        actCode <= '0;
        actSpan <= '0;
      end else begin
        inCode <= inCodeNext;
        inSpan <= inSpanNext;
        if (updThis) begin
          actCode <= inCodeNext;
          actSpan <= inSpanNext;
        end
      end
    end

    assign inCodeFlat[i*CODE_W +: CODE_W] = inCode;
    assign inSpanFlat[i*SPAN_W +: SPAN_W] = inSpan;
    assign codeOut[i*CODE_W +: CODE_W]    = actCode;
    assign spanOut[i*SPAN_W +: SPAN_W]    = actSpan;

    assert_span_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
      inSpan < SPAN_W'(NUM_SPANS));
  end

  assign rbCode = strb.rdActive ? codeOut[strb.chan*CODE_W +: CODE_W]
                                : inCodeFlat[strb.chan*CODE_W +: CODE_W];
  assign rbSpan = strb.rdActive ? spanOut[strb.chan*SPAN_W +: SPAN_W]
                                : inSpanFlat[strb.chan*SPAN_W +: SPAN_W];
  assign rbVal  = strb.rdCode ? rbCode : {{(CODE_W-SPAN_W){1'b0}}, rbSpan};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loReg <= '0;
      hiReg <= '0;
    end else if (strb.rdBack) begin
      loReg <= rbVal[BYTE_W-1:0];
      hiReg <= rbVal[CODE_W-1:BYTE_W];
    end else begin
      if (strb.loWr) loReg <= busWrData;
      if (strb.hiWr) hiReg <= busWrData;
    end
  end

  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.updOne || strb.updAll) |=> ($stable(codeOut) && $stable(spanOut)));
  assert_hi_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.hiWr || strb.rdBack) |=> $stable(hiReg));
endmodule

// File: rtl/dac_cmd_engine.sv
module dac_cmd_engine
  import dac_cmd_pkg::*;
#(
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 5'h08,
  parameter int                LATENCY   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [7:0]               busWrData,
  output logic [7:0]               busRdData,
  output logic [NUM_CH*CODE_W-1:0] codeOut,
  output logic [NUM_CH*SPAN_W-1:0] spanOut,
  output logic                     cmdDone
);
  dacStrobe_t        strb;
  logic              winHit;
  logic [1:0]        winOff;
  logic [BYTE_W-1:0] loReg, hiReg;

  dac_cmd_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .strb(strb), .winHit(winHit), .winOff(winOff),
    .cmdDone(cmdDone)
  );

  dac_cmd_dp u_dp (
    .clk(clk), .rstN(rstN), .busWrData(busWrData), .strb(strb),
    .loReg(loReg), .hiReg(hiReg), .codeOut(codeOut), .spanOut(spanOut)
  );

  always_comb begin
    busRdData = '0;
    if (winHit) begin
      case (winOff)
        2'd0:    busRdData = loReg;
        2'd1:    busRdData = hiReg;
        2'd3:    busRdData = {cmdDone, 7'b0};
        default: busRdData = '0;
      endcase
    end
  end
endmodule

// File: tb/sim_dac_cmd_engine.sv
module sim_dac_cmd_engine;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  busAddr;
  logic        busWrEn;
  logic [7:0]  busWrData;
  logic [7:0]  rd0, rd1;
  logic [63:0] code0, code1;
  logic [15:0] span0, span1;
  logic        done0, done1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dac_cmd_engine #(.ADDR_W(5), .BASE_ADDR(5'h08), .LATENCY(LAT)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rd0), .codeOut(code0), .spanOut(span0), .cmdDone(done0));

  dac_cmd_engine #(.ADDR_W(5), .BASE_ADDR(5'h0C), .LATENCY(LAT)) u1 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rd1), .codeOut(code1), .spanOut(span1), .cmdDone(done1));

  typedef struct packed {
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  cmd;
    logic [63:0] code;
    logic [15:0] span;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'h34, 8'h12, 8'h72, 64'h0000_0000_1234_0000, 16'h0000}, // R7 code+update ch1
    '{8'h03, 8'hFF, 8'h62, 64'h0000_0000_1234_0000, 16'h0030}, // R7 span+update ch1, R4 high ignored
    '{8'hCD, 8'hAB, 8'h3F, 64'h0000_0000_1234_0000, 16'h0030}, // R9 R3 write all inputs only
    '{8'hCD, 8'hAB, 8'h40, 64'h0000_0000_1234_ABCD, 16'h0030}, // R5 update ch0
    '{8'hCD, 8'hAB, 8'h50, 64'hABCD_ABCD_ABCD_ABCD, 16'h0030}, // R6 update all
    '{8'h05, 8'h00, 8'h26, 64'hABCD_ABCD_ABCD_ABCD, 16'h0030}, // R4 span ch3 input only
    '{8'h11, 8'h22, 8'h94, 64'hABCD_2211_ABCD_ABCD, 16'h5030}, // R8 code ch2 + update all
    '{8'h02, 8'h00, 8'h8F, 64'hABCD_2211_ABCD_ABCD, 16'h2222}, // R8 R9 span all + update all
    '{8'h07, 8'h00, 8'h6C, 64'hABCD_2211_ABCD_ABCD, 16'h2222}, // R4 illegal span rejected
    '{8'h00, 8'h00, 8'hF0, 64'hABCD_2211_ABCD_ABCD, 16'h2222}  // R11 no operation
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = rd0;
  endtask

  // Issue a command to u0 and check the completion timing (R11).
  task automatic issueCmd(input logic [7:0] c);
    int n;
    busWrite(5'h0A, c);
    chk(done0 == 1'b0, "R11 done clear", 64'(done0), 64'd0);
    n = 0;
    while (!done0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == LAT, "R11 done latency", 64'(n), 64'(LAT));
  endtask

  task automatic loadData(input logic [7:0] lo, input logic [7:0] hi);
    busWrite(5'h08, lo);
    busWrite(5'h09, hi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [63:0] codeKeep;
    logic [15:0] spanKeep;
    rstN = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(code0 == '0, "R1 codes", code0, 64'd0);
    chk(span0 == '0, "R1 spans", 64'(span0), 64'd0);
    chk(done0 == 1'b1, "R1 done", 64'(done0), 64'd1);
    readReg(5'h0B, v); chk(v == 8'h80, "R1 R2 status", 64'(v), 64'h80);
    readReg(5'h08, v); chk(v == 8'h00, "R1 low byte", 64'(v), 64'h0);
    readReg(5'h09, v); chk(v == 8'h00, "R1 high byte", 64'(v), 64'h0);

    // Table walk over the command set
    for (int k = 0; k < 10; k++) begin
      loadData(VECS[k].lo, VECS[k].hi);
      issueCmd(VECS[k].cmd);
      chk(code0 == VECS[k].code, $sformatf("table %0d code", k), code0, VECS[k].code);
      chk(span0 == VECS[k].span, $sformatf("table %0d span", k), 64'(span0), 64'(VECS[k].span));
    end

    // R3 write input code only
    loadData(8'h99, 8'h88);
    issueCmd(8'h30);
    chk(code0 == 64'hABCD_2211_ABCD_ABCD, "R3 active unchanged", code0, 64'hABCD_2211_ABCD_ABCD);

    // R10 readback of input and active registers
    issueCmd(8'hB0);
    readReg(5'h08, v); chk(v == 8'h99, "R10 input code lo", 64'(v), 64'h99);
    readReg(5'h09, v); chk(v == 8'h88, "R10 input code hi", 64'(v), 64'h88);
    issueCmd(8'hD0);
    readReg(5'h08, v); chk(v == 8'hCD, "R10 active code lo", 64'(v), 64'hCD);
    readReg(5'h09, v); chk(v == 8'hAB, "R10 active code hi", 64'(v), 64'hAB);
    busWrite(5'h08, 8'h04);
    issueCmd(8'h22);
    issueCmd(8'hA2);
    readReg(5'h08, v); chk(v == 8'h04, "R10 input span", 64'(v), 64'h04);
    readReg(5'h09, v); chk(v == 8'h00, "R10 span high byte", 64'(v), 64'h00);
    issueCmd(8'hC2);
    readReg(5'h08, v); chk(v == 8'h02, "R10 active span", 64'(v), 64'h02);

    // R4 illegal span leaves input span of ch2 at 2
    busWrite(5'h08, 8'h06);
    issueCmd(8'h24);
    issueCmd(8'hA4);
    readReg(5'h08, v); chk(v == 8'h02, "R4 rejected span", 64'(v), 64'h02);

    // R4 R7 span with junk high byte, write+update ch0
    loadData(8'h01, 8'hFF);
    issueCmd(8'h60);
    chk(span0 == 16'h2221, "R4 R7 span ch0", 64'(span0), 64'h2221);
    chk(code0 == 64'hABCD_2211_ABCD_8899, "R7 code ch0 from input", code0, 64'hABCD_2211_ABCD_8899);

    // R2 status write and out-of-window writes are ignored
    codeKeep = code0; spanKeep = span0;
    busWrite(5'h0B, 8'h00);
    chk(done0 == 1'b1, "R2 status write", 64'(done0), 64'd1);
    busWrite(5'h10, 8'h5F);
    busWrite(5'h00, 8'h7F);
    repeat (LAT + 1) @(negedge clk);
    chk(code0 == codeKeep && span0 == spanKeep, "R2 outside window", code0, codeKeep);
    readReg(5'h0A, v); chk(v == 8'h00, "R2 command reads 0", 64'(v), 64'h0);
    readReg(5'h12, v); chk(v == 8'h00, "R2 outside read", 64'(v), 64'h0);

    // R12 second instance four bytes higher
    busWrite(5'h0C, 8'h55);
    busWrite(5'h0D, 8'h66);
    busWrite(5'h0E, 8'h70);
    repeat (LAT + 1) @(negedge clk);
    chk(code1[15:0] == 16'h6655, "R12 second instance code", 64'(code1[15:0]), 64'h6655);
    chk(done1 == 1'b1, "R12 second instance done", 64'(done1), 64'd1);
    chk(code0 == codeKeep, "R12 first instance untouched", code0, codeKeep);
    readReg(5'h08, v); chk(v == 8'h01, "R12 first low byte", 64'(v), 64'h01);

    // R11 undefined opcode changes nothing
    issueCmd(8'h1F);
    chk(code0 == codeKeep && span0 == spanKeep, "R11 undefined op", code0, codeKeep);

    // R6 update-all ignores the channel field
    loadData(8'h44, 8'h33);
    issueCmd(8'h3F);
    issueCmd(8'h52);
    chk(code0 == 64'h3344_3344_3344_3344, "R6 all codes", code0, 64'h3344_3344_3344_3344);
    chk(span0 == 16'h2241, "R6 all spans", 64'(span0), 64'h2241);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule